// File: doc/BRIEF.md
# CCD Frame Readout Sequencer

This block sequences the whole frame of an interline CCD sensor. It runs on a system clock and advances one step for each cycle in which a pixel-rate enable is high. Each frame starts with a one-step clear/setup slot. A photodiode transfer follows when one is due. Then vertical row shifts alternate with horizontal line readouts until every row is out, and the block goes back to clear/setup. It drives the two vertical clock phases, the third-level transfer control, the left and right horizontal clock pairs, the shutter pulse and an integration flag. It also exports its pixel, line and vertical-transfer counters so that the sample and clamp timing logic can align with them.

Four mode inputs set the shape of the frame: single or dual output, 2x2 binning, a multi-frame integration count N and an electronic-shutter line selector M. All durations are parameters counted in pixel steps. The defaults match a large sensor: 4200 or 2144 pixel steps per line and 2736 rows.

Top module: `ccd_readout_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every clock, pulse and flag output is 0 and all three exported counters are 0.
- R2: A photodiode transfer is four phases in a row, lasting T3P, TV3, T3D and TDD steps. `v2_clk` is high during the first three phases. `v3rd` is high only during the second phase. `v1_clk` stays low throughout.
- R3: A vertical row shift lasts VDLY+VCCD+HDLY steps. `v1_clk` is high for the first VCCD/2 steps after VDLY. `v2_clk` is high for the next VCCD/2 steps. The two are never high together.
- R4: A line readout lasts LINE_SINGLE steps when `dual_out`=0 and LINE_DUAL steps when `dual_out`=1. `h1_clk` is high on even pixel steps (starting at step 0) and `h2_clk` on odd ones.
- R5: When `dual_out`=0, `h1r_clk`/`h2r_clk` equal `h1_clk`/`h2_clk`. When `dual_out`=1 they are swapped and equal `h2_clk`/`h1_clk`.
- R6: A frame holds FRAME_LINES line readouts, each one preceded by a row shift. `line_cnt` gives the number of lines already read in the current frame. After the last line the block returns to clear/setup.
- R7: With `bin2x2`=1, two row shifts come before each line readout and a frame holds FRAME_LINES/2 lines.
- R8: Starting from reset, a photodiode transfer happens in the first frame and then in every (N+1)-th frame, where N=`multi_frames`. The frames in between are read out with no transfer.
- R9: With `shut_mode`=M nonzero, after the line readout that brings `line_cnt` to SHUT_STEP*M, `shut_pulse` is high for TS steps and TS+TSD steps pass before the next row shift. M=0, or a target that equals or exceeds the frame's line count, gives no pulse.
- R10: The mode inputs are sampled only in the clear/setup step. A change made during a frame takes effect in the next frame.
- R11: `integrating` is 0 during each photodiode transfer and 1 from the end of the first transfer onward, including through frames that skip the transfer.
- R12: The sequence advances only on cycles with `pix_en`=1. Every duration in clock cycles scales with the enable period.
- R13: During a line readout `pix_cnt` equals the pixel step index, and during a row shift `vx_cnt` equals the step index within the shift. Both are 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-rate step enable |
| dual_out | input | 1 | 1 = dual output, 0 = single output |
| bin2x2 | input | 1 | 1 = 2x2 binning |
| multi_frames | input | 3 | Multi-frame integration count N |
| shut_mode | input | 3 | Shutter line selector M, 0 = off |
| v1_clk | output | 1 | Vertical phase 1 |
| v2_clk | output | 1 | Vertical phase 2 |
| v3rd | output | 1 | Third-level transfer control |
| h1_clk | output | 1 | Left horizontal phase 1 |
| h2_clk | output | 1 | Left horizontal phase 2 |
| h1r_clk | output | 1 | Right-half horizontal phase 1 |
| h2r_clk | output | 1 | Right-half horizontal phase 2 |
| shut_pulse | output | 1 | Electronic shutter pulse |
| integrating | output | 1 | High while charge integrates |
| pix_cnt | output | PIX_W | Pixel step within line readout |
| line_cnt | output | LINE_W | Lines read in current frame |
| vx_cnt | output | VX_W | Step within row shift |

## Verification
The assertions assume only a synchronous reset at start-up. They hold for any pattern on `pix_en` and for mode inputs that change at any time, because they only relate output pins to one another: vertical phases exclusive, horizontal pairs exclusive and copied or swapped, the shutter pulse isolated, third-level control inside the V2 window. The stimulus keeps `pix_en` periodic, with a period of one or two clocks, so that the expected gaps between events are exact multiples. It changes modes either under reset or once in the middle of a frame, to show that they are sampled at the frame boundary. The shortened timing parameters keep every frame to a few hundred cycles.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_CLEAR = 3'd0,
    ST_DIODE = 3'd1,
    ST_VXFER = 3'd2,
    ST_LINE  = 3'd3,
    ST_SHUT  = 3'd4
  } seq_state_t;

  typedef struct packed {
    logic       dual;
    logic       bin;
    logic [2:0] multi;
    logic [2:0] shut;
  } seq_cfg_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ccd_seq_cfg.sv
module ccd_seq_cfg
  import ccd_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  seq_cfg_t cfg_in,
  output seq_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (load) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/ccd_seq_fsm.sv
module ccd_seq_fsm
  import ccd_seq_pkg::*;
#(
  parameter int T3P         = 750,
  parameter int TV3         = 360,
  parameter int T3D         = 750,
  parameter int TDD         = 1500,
  parameter int VPERIOD     = 604,
  parameter int LINE_SINGLE = 4200,
  parameter int LINE_DUAL   = 2144,
  parameter int FRAME_LINES = 2736,
  parameter int SHUT_STEP   = 342,
  parameter int TSHUT       = 210,
  parameter int TW          = 13,
  parameter int LW          = 12
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [2:0]    multi_in,
  input  seq_cfg_t      cfg,
  output seq_state_t    state,
  output logic [TW-1:0] tcnt,
  output logic [1:0]    dphase,
  output logic [LW-1:0] lcnt,
  output logic          seen
);
  logic [2:0]    skip;
  logic          bin_ph;
  logic [TW-1:0] plen, llen;
  logic [LW-1:0] ltot, lnext;
  logic [31:0]   shut_line;
  logic          shut_hit;

  always_comb begin
    case (dphase)
      2'd0:    plen = TW'(T3P);
      2'd1:    plen = TW'(TV3);
      2'd2:    plen = TW'(T3D);
      default: plen = TW'(TDD);
    endcase
    llen      = cfg.dual ? TW'(LINE_DUAL) : TW'(LINE_SINGLE);
    ltot      = cfg.bin ? LW'(FRAME_LINES / 2) : LW'(FRAME_LINES);
    lnext     = lcnt + 1'b1;
    shut_line = 32'(SHUT_STEP) * 32'(cfg.shut);
    shut_hit  = (cfg.shut != 3'd0) && (shut_line == 32'(lnext));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_CLEAR;
      tcnt   <= '0;
      dphase <= '0;
      lcnt   <= '0;
      seen   <= 1'b0;
      skip   <= '0;
      bin_ph <= 1'b0;
    end else if (en) begin
      case (state)
        ST_CLEAR: begin
          tcnt   <= '0;
          dphase <= '0;
          lcnt   <= '0;
          bin_ph <= 1'b0;
          if (skip == 3'd0) begin
            skip  <= multi_in;
            state <= ST_DIODE;
          end else begin
            skip  <= skip - 3'd1;
            state <= ST_VXFER;
          end
        end
        ST_DIODE: begin
          if (tcnt == plen - 1'b1) begin
            tcnt <= '0;
            if (dphase == 2'd3) begin
              seen  <= 1'b1;
              state <= ST_VXFER;
            end else begin
              dphase <= dphase + 2'd1;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_VXFER: begin
          if (tcnt == TW'(VPERIOD - 1)) begin
            tcnt <= '0;
            if (cfg.bin && !bin_ph) begin
              bin_ph <= 1'b1;
            end else begin
              bin_ph <= 1'b0;
              state  <= ST_LINE;
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_LINE: begin
          if (tcnt == llen - 1'b1) begin
            tcnt <= '0;
            lcnt <= lnext;
            if (lnext == ltot)  state <= ST_CLEAR;
            else if (shut_hit)  state <= ST_SHUT;
            else                state <= ST_VXFER;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_SHUT: begin
          if (tcnt == TW'(TSHUT - 1)) begin
            tcnt  <= '0;
            state <= ST_VXFER;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= ST_CLEAR;
      endcase
    end
  end
endmodule

// File: rtl/ccd_seq_out.sv
module ccd_seq_out
  import ccd_seq_pkg::*;
#(
  parameter int VDLY   = 4,
  parameter int VCCD   = 300,
  parameter int TS     = 150,
  parameter int TW     = 13,
  parameter int LW     = 12,
  parameter int PIX_W  = 13,
  parameter int VX_W   = 10
)(
  input  logic             clk,
  input  logic             rst,
  input  seq_state_t       state,
  input  logic [TW-1:0]    tcnt,
  input  logic [1:0]       dphase,
  input  logic [LW-1:0]    lcnt,
  input  logic             seen,
  input  logic             dual,
  output logic             v1_clk,
  output logic             v2_clk,
  output logic             v3rd,
  output logic             h1_clk,
  output logic             h2_clk,
  output logic             h1r_clk,
  output logic             h2r_clk,
  output logic             shut_pulse,
  output logic             integrating,
  output logic [PIX_W-1:0] pix_cnt,
  output logic [LW-1:0]    line_cnt,
  output logic [VX_W-1:0]  vx_cnt
);
  localparam logic [TW-1:0] V1_LO = TW'(VDLY);
  localparam logic [TW-1:0] V1_HI = TW'(VDLY + VCCD / 2);
  localparam logic [TW-1:0] V2_HI = TW'(VDLY + 2 * (VCCD / 2));

  logic in_line, in_vx, h1n, h2n;

  always_comb begin
    in_line = (state == ST_LINE);
    in_vx   = (state == ST_VXFER);
    h1n     = in_line && !tcnt[0];
    h2n     = in_line && tcnt[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_clk      <= 1'b0;
      v2_clk      <= 1'b0;
      v3rd        <= 1'b0;
      h1_clk      <= 1'b0;
      h2_clk      <= 1'b0;
      h1r_clk     <= 1'b0;
      h2r_clk     <= 1'b0;
      shut_pulse  <= 1'b0;
      integrating <= 1'b0;
      pix_cnt     <= '0;
      line_cnt    <= '0;
      vx_cnt      <= '0;
    end else begin
      v1_clk      <= in_vx && (tcnt >= V1_LO) && (tcnt < V1_HI);
      v2_clk      <= ((state == ST_DIODE) && (dphase != 2'd3)) ||
                     (in_vx && (tcnt >= V1_HI) && (tcnt < V2_HI));
      v3rd        <= (state == ST_DIODE) && (dphase == 2'd1);
      h1_clk      <= h1n;
      h2_clk      <= h2n;
      h1r_clk     <= dual ? h2n : h1n;
      h2r_clk     <= dual ? h1n : h2n;
      shut_pulse  <= (state == ST_SHUT) && (tcnt < TW'(TS));
      integrating <= seen && (state != ST_DIODE);
      pix_cnt     <= in_line ? tcnt[PIX_W-1:0] : '0;
      line_cnt    <= lcnt;
      vx_cnt      <= in_vx ? tcnt[VX_W-1:0] : '0;
    end
  end
endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccd_seq_pkg::*;
#(
  parameter int T3P         = 750,
  parameter int TV3         = 360,
  parameter int T3D         = 750,
  parameter int TDD         = 1500,
  parameter int VDLY        = 4,
  parameter int VCCD        = 300,
  parameter int HDLY        = 300,
  parameter int LINE_SINGLE = 4200,
  parameter int LINE_DUAL   = 2144,
  parameter int FRAME_LINES = 2736,
  parameter int SHUT_STEP   = 342,
  parameter int TS          = 150,
  parameter int TSD         = 60,
  localparam int VPERIOD    = VDLY + VCCD + HDLY,
  localparam int PIX_W      = $clog2(imax(LINE_SINGLE, LINE_DUAL)),
  localparam int LINE_W     = $clog2(FRAME_LINES + 1),
  localparam int VX_W       = $clog2(VPERIOD)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              pix_en,
  input  logic              dual_out,
  input  logic              bin2x2,
  input  logic [2:0]        multi_frames,
  input  logic [2:0]        shut_mode,
  output logic              v1_clk,
  output logic              v2_clk,
  output logic              v3rd,
  output logic              h1_clk,
  output logic              h2_clk,
  output logic              h1r_clk,
  output logic              h2r_clk,
  output logic              shut_pulse,
  output logic              integrating,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_cnt,
  output logic [VX_W-1:0]   vx_cnt
);
  localparam int TMAX = imax(imax(imax(LINE_SINGLE, LINE_DUAL), imax(VPERIOD, TS + TSD)),
                             imax(imax(T3P, TV3), imax(T3D, TDD)));
  localparam int TW   = $clog2(TMAX + 1);

  seq_cfg_t          cfg_in, cfg_q;
  seq_state_t        state;
  logic [TW-1:0]     tcnt;
  logic [1:0]        dphase;
  logic [LINE_W-1:0] lcnt;
  logic              seen;

  assign cfg_in = '{dual: dual_out, bin: bin2x2, multi: multi_frames, shut: shut_mode};

  ccd_seq_cfg u_cfg (
    .clk(clk), .rst(rst), .load(pix_en && (state == ST_CLEAR)),
    .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  ccd_seq_fsm #(
    .T3P(T3P), .TV3(TV3), .T3D(T3D), .TDD(TDD), .VPERIOD(VPERIOD),
    .LINE_SINGLE(LINE_SINGLE), .LINE_DUAL(LINE_DUAL), .FRAME_LINES(FRAME_LINES),
    .SHUT_STEP(SHUT_STEP), .TSHUT(TS + TSD), .TW(TW), .LW(LINE_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .en(pix_en), .multi_in(multi_frames), .cfg(cfg_q),
    .state(state), .tcnt(tcnt), .dphase(dphase), .lcnt(lcnt), .seen(seen)
  );

  ccd_seq_out #(
    .VDLY(VDLY), .VCCD(VCCD), .TS(TS), .TW(TW), .LW(LINE_W),
    .PIX_W(PIX_W), .VX_W(VX_W)
  ) u_out (
    .clk(clk), .rst(rst), .state(state), .tcnt(tcnt), .dphase(dphase),
    .lcnt(lcnt), .seen(seen), .dual(cfg_q.dual),
    .v1_clk(v1_clk), .v2_clk(v2_clk), .v3rd(v3rd), .h1_clk(h1_clk),
    .h2_clk(h2_clk), .h1r_clk(h1r_clk), .h2r_clk(h2r_clk),
    .shut_pulse(shut_pulse), .integrating(integrating),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .vx_cnt(vx_cnt)
  );
endmodule

// File: rtl/ccd_readout_seq_chk.sv
module ccd_readout_seq_chk (
  input logic clk,
  input logic rst,
  input logic v1_clk,
  input logic v2_clk,
  input logic v3rd,
  input logic h1_clk,
  input logic h2_clk,
  input logic h1r_clk,
  input logic h2r_clk,
  input logic shut_pulse,
  input logic integrating
);
  p_v3rd_in_v2_r2: assert property (@(posedge clk) disable iff (rst) v3rd |-> v2_clk);
  p_vphase_excl_r3: assert property (@(posedge clk) disable iff (rst) !(v1_clk && v2_clk));
  p_hphase_excl_r4: assert property (@(posedge clk) disable iff (rst) !(h1_clk && h2_clk));
  p_right_half_r5: assert property (@(posedge clk) disable iff (rst)
    (h1r_clk == h1_clk && h2r_clk == h2_clk) || (h1r_clk == h2_clk && h2r_clk == h1_clk));
  p_shut_alone_r9: assert property (@(posedge clk) disable iff (rst)
    shut_pulse |-> !(v1_clk || v2_clk || h1_clk || h2_clk));
  p_no_integ_xfer_r11: assert property (@(posedge clk) disable iff (rst) v3rd |-> !integrating);
endmodule

bind ccd_readout_seq ccd_readout_seq_chk u_chk (
  .clk(clk), .rst(rst), .v1_clk(v1_clk), .v2_clk(v2_clk), .v3rd(v3rd),
  .h1_clk(h1_clk), .h2_clk(h2_clk), .h1r_clk(h1r_clk), .h2r_clk(h2r_clk),
  .shut_pulse(shut_pulse), .integrating(integrating)
);

// File: tb/ccd_readout_seq_tb.sv
module ccd_readout_seq_tb;
  localparam int T3P = 6, TV3 = 4, T3D = 5, TDD = 7;
  localparam int VDLY = 2, VCCD = 6, HDLY = 3, VP = VDLY + VCCD + HDLY;
  localparam int LS = 10, LD = 6, FL = 8, SS = 1, TS = 3, TSD = 2;
  localparam int DLEN = T3P + TV3 + T3D + TDD;

  logic clk = 0, rst = 1, pix_en = 1, dual_out = 0, bin2x2 = 0;
  logic [2:0] multi_frames = 0, shut_mode = 0;
  logic v1_clk, v2_clk, v3rd, h1_clk, h2_clk, h1r_clk, h2r_clk, shut_pulse, integrating;
  logic [3:0] pix_cnt, line_cnt, vx_cnt;

  always #4 clk = ~clk;

  ccd_readout_seq #(
    .T3P(T3P), .TV3(TV3), .T3D(T3D), .TDD(TDD), .VDLY(VDLY), .VCCD(VCCD),
    .HDLY(HDLY), .LINE_SINGLE(LS), .LINE_DUAL(LD), .FRAME_LINES(FL),
    .SHUT_STEP(SS), .TS(TS), .TSD(TSD)
  ) u_dut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .dual_out(dual_out), .bin2x2(bin2x2),
    .multi_frames(multi_frames), .shut_mode(shut_mode), .v1_clk(v1_clk),
    .v2_clk(v2_clk), .v3rd(v3rd), .h1_clk(h1_clk), .h2_clk(h2_clk),
    .h1r_clk(h1r_clk), .h2r_clk(h2r_clk), .shut_pulse(shut_pulse),
    .integrating(integrating), .pix_cnt(pix_cnt), .line_cnt(line_cnt), .vx_cnt(vx_cnt)
  );

  typedef struct { int kind; int len; int gap; int lidx; bit dual; } ev_t;
  ev_t q[$];
  int checks = 0, fails = 0;
  int en_div = 1;
  int t_abs, t_prev, skip;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int len, input int at, input int lidx, input bit dual);
    ev_t e;
    e.kind = kind; e.len = len * en_div; e.lidx = lidx; e.dual = dual;
    e.gap = (t_prev < 0) ? -1 : (at - t_prev) * en_div;
    t_prev = at;
    q.push_back(e);
  endtask

  // expected timeline of one frame, in pixel steps, from the requirements
  task automatic add_frame(input bit dual, input bit bin, input int multi, input int shut);
    int lines, len;
    bit diode;
    if (skip == 0) begin diode = 1; skip = multi; end
    else begin diode = 0; skip--; end
    t_abs += 1;
    if (diode) begin
      push(0, TV3, t_abs + T3P, 0, dual);
      t_abs += DLEN;
    end
    lines = bin ? FL / 2 : FL;
    len = dual ? LD : LS;
    for (int k = 0; k < lines; k++) begin
      for (int b = 0; b < (bin ? 2 : 1); b++) begin
        push(1, VCCD / 2, t_abs + VDLY, 0, dual);
        t_abs += VP;
      end
      push(2, len, t_abs, k, dual);
      t_abs += len;
      if ((k + 1) < lines && shut != 0 && (k + 1) == SS * shut) begin
        push(3, TS, t_abs, k + 1, dual);
        t_abs += TS + TSD;
      end
    end
  endtask

  // pixel enable pattern
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      pix_en = (ph == 0);
      ph = (ph + 1) % en_div;
    end
  end

  // monitor: measure bursts on output pins and compare with the scoreboard
  int cyc = 0, mon_last = -1;
  bit act[4];
  int st[4], ln[4], lc[4];
  bit okA[4], okB[4], okS[4], okD[4];

  task automatic finish_ev(input int k);
    ev_t e;
    string rl, rg;
    if (q.size() == 0) return;
    e = q.pop_front();
    rl = (k == 0) ? "R2" : (k == 1) ? "R3" : (k == 2) ? "R4" : "R9";
    rg = (k == 0) ? "R8" : (k == 1) ? "R7" : (k == 2) ? "R6" : "R9";
    chk(e.kind == k, "R6", "event kind", k, e.kind);
    chk(ln[k] == e.len, rl, "burst length", ln[k], e.len);
    if (e.gap >= 0 && mon_last >= 0) chk((st[k] - mon_last) == e.gap, rg, "gap", st[k] - mon_last, e.gap);
    mon_last = st[k];
    case (k)
      0: begin
        chk(okA[0], "R2", "v2 high over third level", okA[0], 1);
        chk(okB[0], "R11", "integrating low in transfer", okB[0], 1);
      end
      1: chk(okA[1], "R13", "vx_cnt track", okA[1], 1);
      2: begin
        chk(okA[2], "R4", "h1/h2 alternation", okA[2], 1);
        chk(e.dual ? okD[2] : okS[2], "R5", "right-half clocks", 0, 1);
        chk(okB[2], "R13", "pix_cnt track", okB[2], 1);
        chk(okS[3], "R11", "integrating high in readout", okS[3], 1);
        chk(lc[2] == e.lidx, "R6", "line_cnt", lc[2], e.lidx);
      end
      default: chk(lc[3] == e.lidx, "R9", "shutter after line", lc[3], e.lidx);
    endcase
  endtask

  initial begin
    bit sig[4];
    forever begin
      @(negedge clk);
      cyc++;
      if (rst) begin
        for (int k = 0; k < 4; k++) act[k] = 0;
        mon_last = -1;
      end else begin
        sig[0] = v3rd; sig[1] = v1_clk; sig[2] = h1_clk | h2_clk; sig[3] = shut_pulse;
        for (int k = 0; k < 4; k++) begin
          if (sig[k]) begin
            if (!act[k]) begin
              act[k] = 1; st[k] = cyc; ln[k] = 0;
              okA[k] = 1; okB[k] = 1; okS[k] = 1; okD[k] = 1;
              if (k == 2) okS[3] = 1;
            end
            case (k)
              0: begin okA[0] &= v2_clk; okB[0] &= !integrating; end
              1: okA[1] &= (int'(vx_cnt) == VDLY + ln[1] / en_div);
              2: begin
                okA[2] &= (h1_clk == (((ln[2] / en_div) % 2) == 0)) && (h1_clk != h2_clk);
                okS[2] &= (h1r_clk == h1_clk) && (h2r_clk == h2_clk);
                okD[2] &= (h1r_clk == h2_clk) && (h2r_clk == h1_clk);
                okB[2] &= (int'(pix_cnt) == ln[2] / en_div);
                okS[3] &= integrating;
                lc[2] = int'(line_cnt);
              end
              default: lc[3] = int'(line_cnt);
            endcase
            ln[k]++;
          end else if (act[k]) begin
            act[k] = 0;
            finish_ev(k);
          end
        end
      end
    end
  end

  task automatic start_run(input bit d, input bit b, input int m, input int s, input int div);
    rst = 1;
    q.delete();
    en_div = div;
    dual_out = d; bin2x2 = b; multi_frames = 3'(m); shut_mode = 3'(s);
    t_abs = 0; t_prev = -1; skip = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    rst = 0;
    while (q.size() != 0 && n < 40000) begin @(negedge clk); n++; end
    chk(q.size() == 0, req, "events still pending", q.size(), 0);
  endtask

  initial begin
    #(190000 * 8);
    fails++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({v1_clk, v2_clk, v3rd, h1_clk, h2_clk, h1r_clk, h2r_clk, shut_pulse, integrating} == 0,
        "R1", "outputs in reset", 0, 0);
    chk(pix_cnt == 0 && line_cnt == 0 && vx_cnt == 0, "R1", "counters in reset", int'(pix_cnt), 0);
    rst = 0;
    @(negedge clk);
    chk(!integrating && !v1_clk && !h1_clk, "R1", "first cycle after reset", int'(integrating), 0);

    // R2 R3 R4 R6: single output, plain frames
    start_run(0, 0, 0, 0, 1);
    add_frame(0, 0, 0, 0); add_frame(0, 0, 0, 0);
    wait_done("R6");

    // R4 R5 R9: dual output with shutter after line 3
    start_run(1, 0, 0, 3, 1);
    add_frame(1, 0, 0, 3); add_frame(1, 0, 0, 3);
    wait_done("R9");

    // R7 R9: binning with shutter at line 2 of 4
    start_run(0, 1, 0, 2, 1);
    add_frame(0, 1, 0, 2); add_frame(0, 1, 0, 2);
    wait_done("R7");

    // R9 boundary: target equals the last line, no pulse
    start_run(0, 1, 0, 4, 1);
    add_frame(0, 1, 0, 4); add_frame(0, 1, 0, 4);
    wait_done("R9");

    // R9 boundary: highest mode, pulse after line 7 of 8
    start_run(0, 0, 0, 7, 1);
    add_frame(0, 0, 0, 7); add_frame(0, 0, 0, 7);
    wait_done("R9");

    // R8 R11: transfer every third frame
    start_run(1, 0, 2, 0, 1);
    for (int f = 0; f < 4; f++) add_frame(1, 0, 2, 0);
    wait_done("R8");

    // R12: enable every other clock
    start_run(1, 1, 0, 1, 2);
    add_frame(1, 1, 0, 1); add_frame(1, 1, 0, 1);
    wait_done("R12");

    // R10: modes changed mid-frame apply from the next frame
    start_run(0, 0, 0, 0, 1);
    add_frame(0, 0, 0, 0); add_frame(1, 0, 0, 5); add_frame(1, 0, 0, 5);
    rst = 0;
    repeat (30) @(negedge clk);
    dual_out = 1; shut_mode = 3'd5;
    wait_done("R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule